// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital control side of an 8-bit successive-approximation analog-to-digital converter. It connects to a processor bus through three active-low strobes: chip select, write (used as the start command) and read. It drives a trial code to an external DAC and comparator, and it takes back one comparator bit that says whether the analog input lies below the trial value. It resolves the result one bit at a time, starting with the most significant bit. It then copies the result into an output latch and signals completion on an active-low interrupt line.

All strobes are brought into the conversion clock domain through two-flop synchronisers. A start request resets the engine and holds it there for as long as the request lasts. The conversion begins only after the request is released, and it is aligned to the next boundary of an 8-clock bit slot. If the interrupt output is fed back to the write strobe while chip select is held low, the block converts continuously. An external start pulse is still needed once after reset to get the loop going.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, intr_no is 1, busy_o is 0, data_oe_o is 0, data_o is 0 and trial_o is 0.
- R2: When cs_ni and wr_ni are both low, within 3 clock edges busy_o goes to 1, intr_no goes to 1 and trial_o goes to 0.
- R3: While cs_ni and wr_ni both stay low, the block holds: trial_o stays 0, busy_o stays 1 and intr_no stays 1, however long the strobe lasts.
- R4: After the strobe is released, intr_no falls at clock edge 68 to 75, counting the first edge that sees wr_ni (or cs_ni) high as edge 1. The spread comes from slot alignment.
- R5: The first trial code of a conversion is 8'h80 (bit 7 is the MSB). Each later bit trial sets the next lower bit.
- R6: In each 8-clock bit slot, cmp_below_i is sampled on the last clock of the slot. If it is 1, the trial bit is cleared; otherwise the bit is kept. With an ideal comparator, the latched result therefore equals the input code, including 8'h00 and 8'hFF (full scale).
- R7: The output latch is loaded only when a conversion completes. intr_no falls one clock after the latch is loaded.
- R8: When cs_ni and rd_ni are both low, data_oe_o is 1, data_o shows the latch and intr_no returns to 1. rd_ni low while cs_ni is high has no effect: data_oe_o stays 0 and intr_no is unchanged.
- R9: A new start during a conversion aborts that conversion. The latch keeps the previous result, and the new conversion delivers its own result.
- R10: With wr_ni tied to intr_no and cs_ni held low, the block restarts by itself after every completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Start strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| cmp_below_i | input | 1 | 1 when the analog input is below trial_o |
| trial_o | output | 8 | Trial code driven to the DAC |
| data_o | output | 8 | Latched result while enabled, 0 otherwise |
| data_oe_o | output | 1 | Data output enable (bus drive) |
| intr_no | output | 1 | Conversion-complete interrupt, active low |
| busy_o | output | 1 | High from a start request until completion |

## Verification
A wrong internal state shows up at the ports in several ways:
- A token that is lost or duplicated in the shift chain produces a wrong code and puts intr_no outside the 68 to 75 edge window. This is visible within one conversion.
- A bad slot-phase decision corrupts a specific bit of data_o. The test codes alternate bit patterns so that every bit position is exercised both set and cleared.
- A latch that updates on an aborted conversion is caught by the read issued mid-conversion after a restart, a few clocks after the abort.
- A hold that leaks into conversion shows as a nonzero trial_o while the start strobe is still low.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_ARM  = 2'd2,
    ST_CONV = 2'd3
  } seq_state_e;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;  // strobes idle high
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import sar_ctrl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SLOT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_req_i,
  input  logic              cmp_below_i,
  output logic [DATA_W-1:0] trial_o,
  output logic [DATA_W-1:0] result_o,
  output logic              xfer_o,
  output logic              busy_o
);
  localparam logic [DATA_W-1:0] MSB_TOKEN = {1'b1, {(DATA_W-1){1'b0}}};

  seq_state_e        state_q;
  logic [SLOT_W-1:0] ph_q;
  logic [DATA_W-1:0] token_q, code_q, decided;
  logic              slot_end;

  assign slot_end = (ph_q == '1);
  assign decided  = cmp_below_i ? (code_q & ~token_q) : code_q;
  assign xfer_o   = (state_q == ST_CONV) && slot_end && token_q[0] && !start_req_i;
  assign result_o = decided;
  assign trial_o  = code_q;
  assign busy_o   = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= '0;
      token_q <= '0;
      code_q  <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;  // free-running slot phase
      if (start_req_i) begin
        state_q <= ST_HOLD;
        token_q <= '0;
        code_q  <= '0;
      end else begin
        unique case (state_q)
          ST_HOLD, ST_ARM: begin
            if (slot_end) begin
              state_q <= ST_CONV;
              token_q <= MSB_TOKEN;
              code_q  <= MSB_TOKEN;
            end else begin
              state_q <= ST_ARM;
            end
          end
          ST_CONV: begin
            if (slot_end) begin
              if (token_q[0]) begin
                state_q <= ST_IDLE;
                token_q <= '0;
                code_q  <= '0;
              end else begin
                token_q <= token_q >> 1;
                code_q  <= decided | (token_q >> 1);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_token_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(token_q));
  p_start_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_req_i |=> (state_q == ST_HOLD) && (trial_o == '0));
  p_conv_token_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV) |-> (token_q != '0));
endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              xfer_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              rd_req_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              intr_no
);
  logic [DATA_W-1:0] latch_q;
  logic              xfer_d_q, intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q  <= '0;
      xfer_d_q <= 1'b0;
      intr_q   <= 1'b0;
    end else begin
      xfer_d_q <= xfer_i;
      if (xfer_i) latch_q <= result_i;
      if (hold_i)        intr_q <= 1'b0;
      else if (xfer_d_q) intr_q <= 1'b1;  // completion wins over a read
      else if (rd_req_i) intr_q <= 1'b0;
    end
  end

  assign data_oe_o = rd_req_i;
  assign data_o    = rd_req_i ? latch_q : '0;
  assign intr_no   = ~intr_q;

  p_latch_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_i |=> $stable(latch_q));
  p_intr_after_xfer_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_d_q && !hold_i) |=> intr_q);
  p_rd_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_i && !xfer_d_q) |=> !intr_q);
  p_hold_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !intr_q);
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl #(
  parameter int DATA_W      = 8,
  parameter int SLOT_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              rd_ni,
  input  logic              cmp_below_i,
  output logic [DATA_W-1:0] trial_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              intr_no,
  output logic              busy_o
);
  logic [2:0]        strb_s;
  logic              start_req, rd_req, xfer;
  logic [DATA_W-1:0] result;

  bus_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rd_ni, wr_ni, cs_ni}),
    .q_o   (strb_s)
  );

  assign start_req = ~strb_s[0] & ~strb_s[1];
  assign rd_req    = ~strb_s[0] & ~strb_s[2];

  conv_seq #(.DATA_W(DATA_W), .SLOT_W(SLOT_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_req_i(start_req),
    .cmp_below_i(cmp_below_i),
    .trial_o    (trial_o),
    .result_o   (result),
    .xfer_o     (xfer),
    .busy_o     (busy_o)
  );

  out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hold_i   (start_req),
    .xfer_i   (xfer),
    .result_i (result),
    .rd_req_i (rd_req),
    .data_o   (data_o),
    .data_oe_o(data_oe_o),
    .intr_no  (intr_no)
  );
endmodule

// File: tb/sar_conv_ctrl_tb_top.sv
module sar_conv_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_drv = 1'b1, rd_n = 1'b1, fr_en = 1'b0;
  logic [7:0] vin = 8'h00;
  logic [7:0] trial, data;
  logic oe, intr_n, busy, cmp_below, wr_n;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  assign cmp_below = (vin < trial);
  assign wr_n = fr_en ? intr_n : wr_drv;

  sar_conv_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .rd_ni(rd_n),
    .cmp_below_i(cmp_below), .trial_o(trial), .data_o(data), .data_oe_o(oe),
    .intr_no(intr_n), .busy_o(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // pulse start for hold_clks, release, return edge count to intr fall
  task automatic convert(input int hold_clks, output int n, input bit chk_first);
    logic [7:0] first;
    @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
    repeat (hold_clks) @(negedge clk);
    wr_drv = 1'b1; cs_n = 1'b1;
    n = 0; first = 8'h00;
    while (intr_n === 1'b1 && n < 300) begin
      @(posedge clk); n++; #1;
      if (first == 8'h00 && trial != 8'h00) first = trial;
    end
    if (chk_first) chk("R5 first trial", first, 8'h80);
  endtask

  task automatic do_read(output logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 oe on read", oe, 1'b1);
    chk("R8 intr cleared by read", intr_n, 1'b1);
    d = data;
    rd_n = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 intr", intr_n, 1'b1); chk("R1 busy", busy, 1'b0);
    chk("R1 oe", oe, 1'b0);       chk("R1 data", data, 8'h00);
    chk("R1 trial", trial, 8'h00);
  endtask

  task automatic t_codes;
    logic [7:0] vals [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h7F};
    logic [7:0] d;
    int n;
    foreach (vals[i]) begin
      vin = vals[i];
      convert(2 + i, n, 1'b1);
      chk_range("R4 latency", n, 68, 75);
      chk("R7 intr low", intr_n, 1'b0);
      do_read(d);
      chk("R6 result", d, vals[i]);
    end
  endtask

  task automatic t_hold;
    int n;
    @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 busy", busy, 1'b1); chk("R2 intr", intr_n, 1'b1);
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      if (trial != 8'h00 || busy != 1'b1 || intr_n != 1'b1) begin
        chk("R3 hold leak", {trial, busy, intr_n}, {8'h00, 1'b1, 1'b1});
        break;
      end
    end
    chk("R3 held trial", trial, 8'h00);
    wr_drv = 1'b1; cs_n = 1'b1;
    n = 0;
    while (intr_n === 1'b1 && n < 300) begin @(posedge clk); n++; #1; end
    chk_range("R4 after wide hold", n, 68, 75);
  endtask

  task automatic t_rd_no_cs;
    @(negedge clk); rd_n = 1'b0; cs_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R8 rd w/o cs oe", oe, 1'b0);
    chk("R8 rd w/o cs intr", intr_n, 1'b0);
    rd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_abort;
    logic [7:0] d;
    int n;
    vin = 8'h11; convert(3, n, 1'b0); do_read(d);
    chk("R6 pre-abort", d, 8'h11);
    vin = 8'h99;
    @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
    repeat (3) @(negedge clk); wr_drv = 1'b1; cs_n = 1'b1;
    repeat (40) @(negedge clk);
    vin = 8'h44;
    convert(3, n, 1'b0);
    chk_range("R9 restart latency", n, 68, 75);
    do_read(d);
    chk("R9 new result", d, 8'h44);
    // abort then read mid-conversion: latch must keep 8'h44
    vin = 8'hEE;
    @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
    repeat (3) @(negedge clk); wr_drv = 1'b1; cs_n = 1'b1;
    repeat (30) @(negedge clk);
    @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
    repeat (3) @(negedge clk); wr_drv = 1'b1;
    repeat (20) @(negedge clk);
    chk("R9 busy after abort", busy, 1'b1);
    rd_n = 1'b0; repeat (3) @(negedge clk);
    chk("R9 latch kept", data, 8'h44);
    rd_n = 1'b1; cs_n = 1'b1;
    n = 0;
    while (intr_n === 1'b1 && n < 300) begin @(posedge clk); n++; #1; end
    do_read(d);
    chk("R9 final result", d, 8'hEE);
  endtask

  task automatic t_freerun;
    logic [7:0] d;
    int n;
    vin = 8'h3C;
    @(negedge clk); cs_n = 1'b0; wr_drv = 1'b0;
    repeat (3) @(negedge clk); wr_drv = 1'b1;
    fr_en = 1'b1;
    n = 0;
    while (intr_n === 1'b1 && n < 300) begin @(posedge clk); n++; #1; end
    chk("R10 first completion", intr_n, 1'b0);
    vin = 8'hC3;
    n = 0;
    while (intr_n === 1'b0 && n < 20) begin @(posedge clk); n++; #1; end
    chk("R10 self restart", intr_n, 1'b1);
    n = 0;
    while (intr_n === 1'b1 && n < 300) begin @(posedge clk); n++; #1; end
    chk("R10 second completion", intr_n, 1'b0);
    n = 0;
    while (intr_n === 1'b0 && n < 20) begin @(posedge clk); n++; #1; end
    @(negedge clk); fr_en = 1'b0; wr_drv = 1'b1; cs_n = 1'b1;
    n = 0;
    while (intr_n === 1'b1 && n < 300) begin @(posedge clk); n++; #1; end
    do_read(d);
    chk("R10 free-run code", d, 8'hC3);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_codes();
    vin = 8'h21;
    begin int n; convert(2, n, 1'b1); end
    t_rd_no_cs();
    t_hold();
    t_abort();
    t_freerun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule